// File: doc/BRIEF.md
# Reconfigurable Lookup-Table Logic Cell

This block is one programmable logic cell. Its function is held as a truth table of `2^K` configuration bits, one bit for every combination of its `K` logic inputs. During normal operation the logic inputs form an index into that table, and the selected bit is the cell's function value. The table therefore acts as a one-bit-wide read-only store. A new function is installed by writing new table contents. The logic inputs and the surrounding wiring do not change.

Configuration arrives on a serial shift chain that has its own enable and data pins. Each clocked cycle with the enable high moves one bit in. The bit that falls off the far end appears on a serial output, so several cells can be strung together and loaded from one stream. One extra configuration bit chooses what drives the cell output: either the table value directly, or the value captured in a state flip-flop one clock earlier. The flip-flop has a clock enable. It does not capture while configuration is active. Configuration is volatile, and reset clears it.

Top module: `lut_cell`

## Requirements
- R1: After reset with no configuration loaded, `cell_out` is 0 for every value of `lut_in`, and `cfg_dout` is 0.
- R2: Each rising clock edge with `cfg_en` high shifts `cfg_din` into the chain. After `2^K+1` such edges, the first bit shifted in is table entry 0, the following bits fill entries 1 to `2^K-1` in turn, and the last bit is the output mode (0 = combinational, 1 = registered).
- R3: In combinational mode, `cell_out` equals table entry number `lut_in` in the same cycle.
- R4: `cfg_dout` shows the oldest bit in the chain. While shifting, it presents the previously loaded stream in the order it was loaded: entry 0 first and the mode bit last.
- R5: While `cfg_en` is low, `cfg_din` has no effect on the stored configuration.
- R6: In registered mode, a rising edge with `ce` high and `cfg_en` low captures table entry `lut_in`, and `cell_out` shows it from that edge on, one cycle after the input was applied.
- R7: With `ce` low, the state flip-flop keeps its value whatever `lut_in` does.
- R8: While `cfg_en` is high, the state flip-flop does not change, even with `ce` high.
- R9: Synchronous reset (`rst` high at a rising edge) clears the whole configuration and the state flip-flop to 0.
- R10: Loading a different table changes the function seen at `cell_out` with no other change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out, for daisy chaining |
| ce | input | 1 | Clock enable of the state flip-flop |
| lut_in | input | K | Logic inputs, used as the table index |
| cell_out | output | 1 | Cell output, combinational or registered |

## Verification
The hardest state to reach from the ports is a state flip-flop that holds a known value across a whole reload while `ce` stays high. The stimulus therefore captures a 1 under one function and moves `lut_in` to an index that is 0 under the incoming function. It then shifts the new registered-mode configuration in with `ce` still asserted. Right after the load, the output must still show the old 1, and only the next edge may bring the new 0. The daisy-chain path is covered the same way: a second stream is shifted over the first, and each bit leaving on `cfg_dout` is compared with the first stream in load order.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    // Output mode carried by the last bit of the configuration stream
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_sel_e;

    // Number of table entries for a k-input cell
    function automatic int unsigned tbl_entries(input int unsigned k);
        return 32'd1 << k;
    endfunction

    // Total configuration stream length: table plus mode bit
    function automatic int unsigned stream_len(input int unsigned k);
        return tbl_entries(k) + 32'd1;
    endfunction

endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain
    import lut_cell_pkg::*;
#(
    parameter int unsigned K = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      shift_en,
    input  logic                      shift_in,
    output logic                      shift_out,
    output logic [tbl_entries(K)-1:0] table_bits,
    output out_sel_e                  mode
);
    localparam int unsigned N = tbl_entries(K);
    localparam int unsigned L = stream_len(K);

    // Index 0 holds the oldest bit; new bits enter at the top
    logic [L-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else if (shift_en) begin
            chain <= {shift_in, chain[L-1:1]};
        end
    end

    assign shift_out  = chain[0];
    assign table_bits = chain[N-1:0];
    assign mode       = out_sel_e'(chain[L-1]);

    assert_shift_entry_R2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (chain[L-1] == $past(shift_in)));

    assert_serial_out_R4: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (shift_out == $past(chain[1])));

    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(chain));

    assert_cfg_clear_R9: assert property (@(posedge clk)
        rst |=> (chain == '0));

endmodule

// File: rtl/lut_mux_tree.sv
module lut_mux_tree
    import lut_cell_pkg::*;
#(
    parameter int unsigned K = 4
) (
    input  logic [tbl_entries(K)-1:0] table_bits,
    input  logic [K-1:0]              sel_in,
    output logic                      f
);
    localparam int unsigned N = tbl_entries(K);

    // Heap-ordered binary tree: node 1 is the root, leaves are N..2N-1
    logic [2*N-1:1] node;

    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign node[N+i] = table_bits[i];
    end

    // A node at depth d is steered by input bit K-1-d (MSB at the root)
    for (genvar d = 0; d < K; d++) begin : g_level
        for (genvar j = (1 << d); j < (1 << (d + 1)); j++) begin : g_node
            assign node[j] = sel_in[K-1-d] ? node[2*j+1] : node[2*j];
        end
    end

    assign f = node[1];

endmodule

// File: rtl/lut_state_ff.sv
module lut_state_ff (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic freeze,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (ce && !freeze) begin
            q <= d;
        end
    end

    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (ce && !freeze) |=> (q == $past(d)));

    assert_ce_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q));

    assert_cfg_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(q));

    assert_state_clear_R9: assert property (@(posedge clk)
        rst |=> !q);

endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
#(
    parameter int unsigned K = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_en,
    input  logic         cfg_din,
    output logic         cfg_dout,
    input  logic         ce,
    input  logic [K-1:0] lut_in,
    output logic         cell_out
);
    localparam int unsigned N = tbl_entries(K);

    logic [N-1:0] table_bits;
    out_sel_e     mode;
    logic         lut_f;
    logic         state_q;

    lut_cfg_chain #(.K(K)) u_chain (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (cfg_en),
        .shift_in   (cfg_din),
        .shift_out  (cfg_dout),
        .table_bits (table_bits),
        .mode       (mode)
    );

    lut_mux_tree #(.K(K)) u_tree (
        .table_bits (table_bits),
        .sel_in     (lut_in),
        .f          (lut_f)
    );

    lut_state_ff u_state (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .freeze (cfg_en),
        .d      (lut_f),
        .q      (state_q)
    );

    // Output select: table value directly or the captured state
    always_comb begin
        case (mode)
            OUT_REG:  cell_out = state_q;
            default:  cell_out = lut_f;
        endcase
    end

    // Tree result must match a direct index of the table contents
    assert_comb_path_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == OUT_COMB) |-> (cell_out == table_bits[lut_in]));

    // Registered mode shows the table value selected one edge earlier
    assert_reg_latency_R6: assert property (@(posedge clk) disable iff (rst)
        ((mode == OUT_REG) && $past(ce) && !$past(cfg_en) && !$past(rst))
            |-> (cell_out == $past(table_bits[lut_in])));

endmodule

// File: tb/lut_cell_test.sv
module lut_cell_test;
    localparam int CLK_PERIOD = 10;
    localparam int K = 4;
    localparam int N = 1 << K;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_en = 1'b0;
    logic         cfg_din = 1'b0;
    logic         cfg_dout;
    logic         ce = 1'b0;
    logic [K-1:0] lut_in = '0;
    logic         cell_out;

    int  errors = 0;
    int  checks = 0;
    bit  finished = 1'b0;

    typedef struct {
        logic  exp;
        bit    on_dout;
        string req;
    } exp_t;

    exp_t sb[$];

    lut_cell #(.K(K)) uut (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_dout (cfg_dout),
        .ce       (ce),
        .lut_in   (lut_in),
        .cell_out (cell_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference functions, written from their meaning
    function automatic logic fn(input int code, input int x);
        logic [K-1:0] v;
        v = K'(x);
        case (code)
            0: return ^v;                      // parity (XOR of all inputs)
            1: return &v;                      // AND of all inputs
            2: return (v[0] & v[1]) | v[3];
            3: return (x < 6);
            default: return 1'b1;              // constant one
        endcase
    endfunction

    function automatic logic [N-1:0] table_of(input int code);
        logic [N-1:0] t;
        for (int i = 0; i < N; i++) t[i] = fn(code, i);
        return t;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic e, input string req);
        exp_t it;
        it.exp = e; it.on_dout = 1'b0; it.req = req;
        sb.push_back(it);
    endtask

    task automatic expect_dout(input logic e, input string req);
        exp_t it;
        it.exp = e; it.on_dout = 1'b1; it.req = req;
        sb.push_back(it);
    endtask

    // Stream: entries 0..N-1, then mode bit; optionally checks outgoing bits
    task automatic load(input logic [N-1:0] tbl, input logic md,
                        input logic [N:0] old_stream, input bit chk);
        logic [N:0] s;
        s = {md, tbl};
        for (int i = 0; i <= N; i++) begin
            if (chk) expect_dout(old_stream[i], "R4");
            cfg_en  = 1'b1;
            cfg_din = s[i];
            tick();
        end
        cfg_en  = 1'b0;
        cfg_din = 1'b0;
    endtask

    // Monitor: compares queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t it;
                logic act;
                it  = sb.pop_front();
                act = it.on_dout ? cfg_dout : cell_out;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s %s: actual=%b expected=%b at %0t",
                             it.req, it.on_dout ? "cfg_dout" : "cell_out",
                             act, it.exp, $time);
                end
            end
        end
    end

    // Driver
    initial begin
        logic [N-1:0] t_xor, t_and, t_c2, t_c3, t_one;
        int prev;
        t_xor = table_of(0);
        t_and = table_of(1);
        t_c2  = table_of(2);
        t_c3  = table_of(3);
        t_one = table_of(9);

        repeat (3) tick();
        rst = 1'b0;

        // R1: empty configuration after reset
        for (int x = 0; x < N; x++) begin
            lut_in = K'(x);
            expect_out(1'b0, "R1");
            expect_dout(1'b0, "R1");
            tick();
        end

        // R2/R3: load parity, combinational; outgoing bits are the zero reset image (R4)
        load(t_xor, 1'b0, '0, 1'b1);
        for (int x = 0; x < N; x++) begin
            lut_in = K'(x);
            expect_out(fn(0, x), "R3");
            tick();
        end

        // R4/R10: shift AND over parity; parity stream must leave in load order
        load(t_and, 1'b0, {1'b0, t_xor}, 1'b1);
        // R5: toggle cfg_din with cfg_en low during the sweep
        for (int x = 0; x < N; x++) begin
            lut_in  = K'(x);
            cfg_din = ~cfg_din;
            expect_out(fn(1, x), "R10");
            expect_out(fn(1, x), "R5");
            tick();
        end
        cfg_din = 1'b0;

        // R6: registered mode, one-cycle latency
        load(t_c2, 1'b1, '0, 1'b0);
        ce = 1'b1;
        prev = 0;
        for (int x = 0; x < N; x++) begin
            int v;
            v = (x * 7 + 3) % N;
            lut_in = K'(v);
            if (x > 0) expect_out(fn(2, prev), "R6");
            prev = v;
            tick();
        end
        expect_out(fn(2, prev), "R6");

        // R7: ce low holds the captured value
        ce = 1'b0;
        for (int x = 0; x < N; x++) begin
            lut_in = K'(x);
            tick();
            expect_out(fn(2, prev), "R7");
        end

        // R8: capture 1 at index 3, reload with ce high, state must not move
        ce = 1'b1;
        lut_in = K'(3);
        tick();
        expect_out(1'b1, "R6");
        lut_in = K'(9);
        load(t_c3, 1'b1, '0, 1'b0);
        expect_out(1'b1, "R8");
        tick();
        expect_out(fn(3, 9), "R10");
        lut_in = K'(2);
        tick();
        expect_out(fn(3, 2), "R6");

        // R9: synchronous reset clears state and configuration
        rst = 1'b1;
        tick();
        rst = 1'b0;
        ce  = 1'b0;
        for (int x = 0; x < N; x += 5) begin
            lut_in = K'(x);
            expect_out(1'b0, "R9");
            expect_dout(1'b0, "R9");
            tick();
        end
        // all-ones table in registered mode, ce low: output is the cleared state
        load(t_one, 1'b1, '0, 1'b0);
        expect_out(1'b0, "R9");
        tick();
        ce = 1'b1;
        tick();
        expect_out(1'b1, "R6");

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule